// File: doc/BRIEF.md
# Adaptive Main-Memory Miss Detector

This block sits beside the load pipeline of a multithreaded core and decides, for each physical thread slot, when an outstanding load has waited long enough to be treated as a main-memory access, so that the slot's thread should be swapped out. Every issued load is given a slot index and a small entry tag. Its age counts up until a completion for the same slot and tag clears it. Once the age reaches the slot's threshold, the load is a miss. After a fixed settling gap, and only while that load is the oldest uncommitted instruction of its thread, the block raises one swap request that carries the slot and the tag.

The threshold for each slot comes from one of two sources. In fixed mode it is a configured per-slot value. In adaptive mode it is a per-slot counter. The counter drops by one each time a miss completes while no other miss to a different cache line overlapped it, so threads with little memory parallelism swap sooner. A programmable period reloads every counter to a configured ceiling.

Top module: `mmd_miss_detector`

## Requirements
- R1: After reset, `swap_req_o` is 0 and `swap_slot_o` and `swap_tag_o` are 0.
- R2: In fixed mode (`adapt_en_i`=0), slot s uses `fix_thr_i[s*8 +: 8]` as its threshold T. If a load is the head of its slot throughout, `swap_req_o` rises on exactly the T+4th rising edge after the edge that accepted the issue. Those four edges are made up of 3 settling cycles after the age first equals T, plus the request register.
- R3: No request is made for a load while `head_load_i[s]` is 0 or `head_tag_i[s*3 +: 3]` names a different tag. If the load's settling gap is already complete when it becomes head, the request rises on the next edge.
- R4: A completion that arrives before the load's age reaches its threshold clears the entry, and no request is ever made for that load.
- R5: A request holds `swap_req_o`=1 with a stable slot and tag until the edge at which `swap_ack_i`=1. It drops on that edge. A load is requested at most once.
- R6: When loads in several slots become eligible in the same cycle, the lowest slot index is requested first. The next slot is requested on the second edge after the acknowledge.
- R7: In adaptive mode (`adapt_en_i`=1), the threshold is the slot's counter, and that counter resets to 25.
- R8: When a miss completes (its age is at least the threshold) with no overlapping miss, the slot's counter decrements by one, but never below `thr_min_i`. If the counter is already at or below the floor, it is set to `thr_min_i`. This happens in either mode.
- R9: A completing miss does not decrement the counter if, while it was outstanding, another miss of the same slot to a different line (`iss_line_i`) existed. Overlapping misses to the same line do not prevent the decrement.
- R10: When `reload_per_i`=P>0, every counter is loaded with `thr_max_i` once every P cycles. When P=0, counters are never reloaded.
- R11: Slots are independent: each has its own entries, threshold and counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adapt_en_i | input | 1 | 1 selects the adaptive counter as the threshold |
| fix_thr_i | input | NUM_SLOTS*THR_W | Fixed threshold for each slot |
| thr_min_i | input | THR_W | Floor of the adaptive counter |
| thr_max_i | input | THR_W | Value the counters are reloaded to |
| reload_per_i | input | PER_W | Reload period in cycles, 0 disables reloading |
| iss_valid_i | input | 1 | Load issue event |
| iss_slot_i | input | SLOT_W | Slot of the issuing load |
| iss_tag_i | input | TAG_W | Entry tag of the issuing load |
| iss_line_i | input | LINE_W | Cache line address of the load |
| cmp_valid_i | input | 1 | Load completion event |
| cmp_slot_i | input | SLOT_W | Slot of the completing load |
| cmp_tag_i | input | TAG_W | Entry tag of the completing load |
| head_load_i | input | NUM_SLOTS | Oldest uncommitted instruction of the slot is a tracked load |
| head_tag_i | input | NUM_SLOTS*TAG_W | Tag of that oldest load, one field per slot |
| swap_req_o | output | 1 | Swap request pending |
| swap_slot_o | output | SLOT_W | Slot to swap |
| swap_tag_o | output | TAG_W | Tag of the missing load |
| swap_ack_i | input | 1 | Acknowledges the pending request |

## Verification
The in-design properties check every cycle that a pending request holds its slot and tag until acknowledged and then drops, that a new request only follows a cycle in which its slot's head signal was high, that no higher slot is chosen over an eligible lower one, and that an entry is only consumed when its slot offered a candidate. The exact request latency for a given threshold, the drift of the adaptive counter under lone and overlapping misses, the floor, the periodic reload and the suppression of early-completing loads are visible only through the bench's scenarios. The bench infers these from the measured latency of probe loads.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int unsigned SWAP_GAP = 3;
  localparam int unsigned GAP_W    = 2;
  typedef logic [GAP_W-1:0] gap_t;
endpackage

// File: rtl/mmd_reload_timer.sv
module mmd_reload_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] per_i,
  output logic             pulse_o
);
  logic [PER_W-1:0] cnt_q;
  logic             hit;

  assign hit     = (per_i != '0) && (cnt_q >= per_i - PER_W'(1));
  assign pulse_o = hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (per_i == '0)    cnt_q <= '0;
    else if (hit)            cnt_q <= '0;
    else                     cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/mmd_thr_ctrl.sv
module mmd_thr_ctrl #(
  parameter int unsigned THR_W   = 8,
  parameter int unsigned DEF_THR = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adapt_en_i,
  input  logic [THR_W-1:0] fix_thr_i,
  input  logic [THR_W-1:0] thr_min_i,
  input  logic [THR_W-1:0] thr_max_i,
  input  logic             reload_i,
  input  logic             lone_done_i,
  output logic [THR_W-1:0] thr_o
);
  logic [THR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= THR_W'(DEF_THR);
    else if (reload_i)    cnt_q <= thr_max_i;
    else if (lone_done_i) cnt_q <= (cnt_q > thr_min_i) ? cnt_q - THR_W'(1) : thr_min_i;
  end

  assign thr_o = adapt_en_i ? cnt_q : fix_thr_i;
endmodule

// File: rtl/mmd_slot_tracker.sv
module mmd_slot_tracker import mmd_pkg::*; #(
  parameter int unsigned LOADS  = 8,
  parameter int unsigned LINE_W = 26,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned TAG_W  = $clog2(LOADS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              iss_en_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic [LINE_W-1:0] iss_line_i,
  input  logic              cmp_en_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  input  logic              head_load_i,
  input  logic [TAG_W-1:0]  head_tag_i,
  input  logic              take_i,
  output logic              cand_o,
  output logic              lone_done_o
);
  logic [LOADS-1:0]  vld_q, conc_q, reqd_q;
  logic [LOADS-1:0]  miss, conc_now;
  logic [THR_W-1:0]  age_q  [LOADS];
  logic [LINE_W-1:0] line_q [LOADS];
  gap_t              gap_q  [LOADS];

  always_comb begin
    for (int i = 0; i < LOADS; i++) miss[i] = vld_q[i] && (age_q[i] >= thr_i);
    for (int i = 0; i < LOADS; i++) begin
      conc_now[i] = 1'b0;
      for (int j = 0; j < LOADS; j++)
        if (j != i && miss[j] && line_q[j] != line_q[i]) conc_now[i] = 1'b1;
    end
  end

  assign cand_o = head_load_i && vld_q[head_tag_i] && !reqd_q[head_tag_i]
                  && (gap_q[head_tag_i] == gap_t'(SWAP_GAP));
  assign lone_done_o = cmp_en_i && miss[cmp_tag_i] && !conc_q[cmp_tag_i]
                       && !conc_now[cmp_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0; conc_q <= '0; reqd_q <= '0;
      for (int i = 0; i < LOADS; i++) begin
        age_q[i] <= '0; line_q[i] <= '0; gap_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LOADS; i++) begin
        if (iss_en_i && iss_tag_i == TAG_W'(i)) begin
          vld_q[i] <= 1'b1; age_q[i] <= '0; line_q[i] <= iss_line_i;
          gap_q[i] <= '0;   conc_q[i] <= 1'b0; reqd_q[i] <= 1'b0;
        end else if (cmp_en_i && cmp_tag_i == TAG_W'(i)) begin
          vld_q[i] <= 1'b0; gap_q[i] <= '0; conc_q[i] <= 1'b0; reqd_q[i] <= 1'b0;
        end else if (vld_q[i]) begin
          if (age_q[i] != '1) age_q[i] <= age_q[i] + THR_W'(1);
          // detection is sticky: once the gap starts it runs to completion
          if ((miss[i] || gap_q[i] != '0) && gap_q[i] != gap_t'(SWAP_GAP))
            gap_q[i] <= gap_q[i] + gap_t'(1);
          conc_q[i] <= conc_q[i] | conc_now[i];
          reqd_q[i] <= reqd_q[i] | (take_i && head_tag_i == TAG_W'(i));
        end
      end
    end
  end

  p_take_only_cand_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> cand_o);
endmodule

// File: rtl/mmd_miss_detector.sv
module mmd_miss_detector #(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned LOADS     = 8,
  parameter int unsigned LINE_W    = 26,
  parameter int unsigned THR_W     = 8,
  parameter int unsigned PER_W     = 16,
  parameter int unsigned DEF_THR   = 25,
  parameter int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  parameter int unsigned TAG_W     = $clog2(LOADS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       adapt_en_i,
  input  logic [NUM_SLOTS*THR_W-1:0] fix_thr_i,
  input  logic [THR_W-1:0]           thr_min_i,
  input  logic [THR_W-1:0]           thr_max_i,
  input  logic [PER_W-1:0]           reload_per_i,
  input  logic                       iss_valid_i,
  input  logic [SLOT_W-1:0]          iss_slot_i,
  input  logic [TAG_W-1:0]           iss_tag_i,
  input  logic [LINE_W-1:0]          iss_line_i,
  input  logic                       cmp_valid_i,
  input  logic [SLOT_W-1:0]          cmp_slot_i,
  input  logic [TAG_W-1:0]           cmp_tag_i,
  input  logic [NUM_SLOTS-1:0]       head_load_i,
  input  logic [NUM_SLOTS*TAG_W-1:0] head_tag_i,
  output logic                       swap_req_o,
  output logic [SLOT_W-1:0]          swap_slot_o,
  output logic [TAG_W-1:0]           swap_tag_o,
  input  logic                       swap_ack_i
);
  logic                 reload;
  logic [NUM_SLOTS-1:0] cand, take, lone_done;
  logic                 sel_found;
  logic [SLOT_W-1:0]    sel_slot;
  logic [TAG_W-1:0]     sel_tag;
  logic                 req_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [TAG_W-1:0]     tag_q;
  logic [NUM_SLOTS-1:0] low_mask;

  mmd_reload_timer #(.PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .per_i(reload_per_i), .pulse_o(reload)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [THR_W-1:0] thr;

    mmd_thr_ctrl #(.THR_W(THR_W), .DEF_THR(DEF_THR)) u_thr (
      .clk_i, .rst_ni, .adapt_en_i,
      .fix_thr_i   (fix_thr_i[s*THR_W +: THR_W]),
      .thr_min_i, .thr_max_i,
      .reload_i    (reload),
      .lone_done_i (lone_done[s]),
      .thr_o       (thr)
    );

    mmd_slot_tracker #(.LOADS(LOADS), .LINE_W(LINE_W), .THR_W(THR_W), .TAG_W(TAG_W)) u_trk (
      .clk_i, .rst_ni,
      .thr_i       (thr),
      .iss_en_i    (iss_valid_i && iss_slot_i == SLOT_W'(s)),
      .iss_tag_i, .iss_line_i,
      .cmp_en_i    (cmp_valid_i && cmp_slot_i == SLOT_W'(s)),
      .cmp_tag_i,
      .head_load_i (head_load_i[s]),
      .head_tag_i  (head_tag_i[s*TAG_W +: TAG_W]),
      .take_i      (take[s]),
      .cand_o      (cand[s]),
      .lone_done_o (lone_done[s])
    );

    assign take[s] = !req_q && sel_found && (sel_slot == SLOT_W'(s));
  end

  // lowest slot index wins
  always_comb begin
    sel_found = 1'b0;
    sel_slot  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (cand[s]) begin
        sel_found = 1'b1;
        sel_slot  = SLOT_W'(s);
      end
  end
  assign sel_tag = head_tag_i[sel_slot*TAG_W +: TAG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; slot_q <= '0; tag_q <= '0;
    end else if (!req_q) begin
      if (sel_found) begin
        req_q <= 1'b1; slot_q <= sel_slot; tag_q <= sel_tag;
      end
    end else if (swap_ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign swap_req_o  = req_q;
  assign swap_slot_o = slot_q;
  assign swap_tag_o  = tag_q;
  assign low_mask    = (NUM_SLOTS'(1) << swap_slot_o) - NUM_SLOTS'(1);

  p_hold_until_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_req_o && !swap_ack_i |=> swap_req_o && $stable(swap_slot_o) && $stable(swap_tag_o));
  p_drop_on_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_req_o && swap_ack_i |=> !swap_req_o);
  p_head_before_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swap_req_o) |-> ($past(head_load_i) & (NUM_SLOTS'(1) << swap_slot_o)) != '0);
  p_lowest_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swap_req_o) |-> ($past(cand) & low_mask) == '0);
endmodule

// File: tb/tb_mmd_miss_detector.sv
module tb_mmd_miss_detector;
  localparam int CLK_P = 10;
  localparam int NS = 2, TW = 3, THW = 8, LW = 26, PW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic adapt_en_i = 1'b0;
  logic [NS*THW-1:0] fix_thr_i = '0;
  logic [THW-1:0] thr_min_i = 8'd5, thr_max_i = 8'd60;
  logic [PW-1:0] reload_per_i = '0;
  logic iss_valid_i = 1'b0, cmp_valid_i = 1'b0, swap_ack_i = 1'b0;
  logic [0:0] iss_slot_i = '0, cmp_slot_i = '0;
  logic [TW-1:0] iss_tag_i = '0, cmp_tag_i = '0;
  logic [LW-1:0] iss_line_i = '0;
  logic [NS-1:0] head_load_i = '0;
  logic [NS*TW-1:0] head_tag_i = '0;
  logic swap_req_o;
  logic [0:0] swap_slot_o;
  logic [TW-1:0] swap_tag_o;

  int n_chk = 0, n_err = 0, cur_min = 5;
  int exp_cnt [NS];
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mmd_miss_detector dut (.*);

  function automatic int dec(int c);
    return (c > cur_min) ? c - 1 : cur_min;
  endfunction

  task automatic tick(); @(negedge clk_i); endtask

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_head(int s, int t, bit on);
    head_load_i[s] = on;
    head_tag_i[s*TW +: TW] = TW'(t);
  endtask

  task automatic issue(int s, int t, int line);
    iss_valid_i = 1; iss_slot_i = 1'(s); iss_tag_i = TW'(t); iss_line_i = LW'(line);
    tick();
    iss_valid_i = 0;
  endtask

  task automatic complete(int s, int t);
    cmp_valid_i = 1; cmp_slot_i = 1'(s); cmp_tag_i = TW'(t);
    tick();
    cmp_valid_i = 0;
  endtask

  task automatic ack();
    swap_ack_i = 1; tick(); swap_ack_i = 0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!swap_req_o && n < 600) begin tick(); n++; end
  endtask

  // measures threshold from request latency; completion is a lone miss
  task automatic probe(int s, int t, int line, int exp_thr, string req);
    int n;
    set_head(s, t, 1);
    issue(s, t, line);
    wait_req(n);
    check_eq(req, n - 4, exp_thr);
    check_eq(req, swap_slot_o * 8 + swap_tag_o, s * 8 + t);
    ack();
    set_head(s, t, 0);
    complete(s, t);
    exp_cnt[s] = dec(exp_cnt[s]);
  endtask

  task automatic watch(int cycles, output bit seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin tick(); seen |= swap_req_o; end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit seen;
    int n;
    exp_cnt[0] = 25; exp_cnt[1] = 25;
    void'($urandom(32'd4242));
    repeat (3) tick();
    // R1 reset state
    check_eq("R1 req", swap_req_o, 0);
    check_eq("R1 slot", swap_slot_o, 0);
    check_eq("R1 tag", swap_tag_o, 0);
    rst_ni = 1; tick();

    // R2 / R11 fixed thresholds per slot
    fix_thr_i[0 +: 8] = 8'd10; fix_thr_i[8 +: 8] = 8'd30;
    probe(0, 2, 'h100, 10, "R2 slot0 fixed");
    probe(1, 5, 'h140, 30, "R11 slot1 fixed");

    // R3 head gating
    set_head(0, 3, 0);
    issue(0, 3, 'h180);
    watch(20, seen); check_eq("R3 head low", seen, 0);
    set_head(0, 4, 1);
    watch(10, seen); check_eq("R3 wrong tag", seen, 0);
    set_head(0, 3, 1);
    tick();
    check_eq("R3 next edge", swap_req_o, 1);
    check_eq("R3 tag", swap_tag_o, 3);
    // R5 hold and single request
    repeat (5) tick();
    check_eq("R5 held", swap_req_o, 1);
    check_eq("R5 stable tag", swap_tag_o, 3);
    ack();
    check_eq("R5 drop", swap_req_o, 0);
    watch(10, seen); check_eq("R5 once", seen, 0);
    set_head(0, 3, 0);
    complete(0, 3); exp_cnt[0] = dec(exp_cnt[0]);

    // R4 early completion
    fix_thr_i[0 +: 8] = 8'd20;
    set_head(0, 1, 1);
    issue(0, 1, 'h1c0);
    repeat (9) tick();
    complete(0, 1);
    watch(40, seen); check_eq("R4 no req", seen, 0);
    set_head(0, 1, 0);

    // R6 priority
    fix_thr_i[0 +: 8] = 8'd8; fix_thr_i[8 +: 8] = 8'd8;
    issue(1, 0, 'h200);
    issue(0, 0, 'h240);
    repeat (20) tick();
    set_head(0, 0, 1); set_head(1, 0, 1);
    tick();
    check_eq("R6 low slot first", swap_req_o * 2 + swap_slot_o, 2);
    ack();
    check_eq("R6 gap", swap_req_o, 0);
    tick();
    check_eq("R6 next slot", swap_req_o * 2 + swap_slot_o, 3);
    ack();
    set_head(0, 0, 0); set_head(1, 0, 0);
    complete(0, 0); exp_cnt[0] = dec(exp_cnt[0]);
    complete(1, 0); exp_cnt[1] = dec(exp_cnt[1]);

    // R7 / R8 adaptive, R10 no reload while period 0
    adapt_en_i = 1;
    probe(0, 6, 'h280, exp_cnt[0], "R7 adaptive thr");
    probe(0, 6, 'h280, exp_cnt[0], "R8 decrement");
    thr_min_i = 8'(exp_cnt[0] - 1); cur_min = exp_cnt[0] - 1;
    probe(0, 6, 'h280, exp_cnt[0], "R8 to floor");
    probe(0, 6, 'h280, exp_cnt[0], "R8 floor hold");
    probe(0, 6, 'h280, exp_cnt[0], "R10 period zero");
    thr_min_i = 8'd5; cur_min = 5;

    // R9 concurrent different lines suppress decrement
    issue(0, 0, 'h300);
    issue(0, 1, 'h340);
    repeat (40) tick();
    complete(0, 0); complete(0, 1);
    probe(0, 2, 'h380, exp_cnt[0], "R9 diff lines");
    issue(0, 0, 'h3c0);
    issue(0, 1, 'h3c0);
    repeat (40) tick();
    complete(0, 0); exp_cnt[0] = dec(exp_cnt[0]);
    complete(0, 1); exp_cnt[0] = dec(exp_cnt[0]);
    probe(0, 2, 'h380, exp_cnt[0], "R9 same line");

    // R11 slot1 counter untouched by slot0
    probe(1, 4, 'h400, exp_cnt[1], "R11 slot1 counter");

    // R10 periodic reload
    thr_max_i = 8'd60; reload_per_i = 16'd2000;
    repeat (2100) tick();
    exp_cnt[0] = 60; exp_cnt[1] = 60;
    probe(0, 5, 'h440, exp_cnt[0], "R10 reload slot0");
    probe(1, 5, 'h480, exp_cnt[1], "R10 reload slot1");
    reload_per_i = 16'd0;

    // random mix, fixed mode: R2 latency and R4 early completion
    adapt_en_i = 0;
    for (int i = 0; i < 24; i++) begin
      int s, t, thr, k;
      s = int'($urandom % 2); t = int'($urandom % 8); thr = int'($urandom % 41);
      fix_thr_i[s*8 +: 8] = 8'(thr);
      if (($urandom % 2) == 1 && thr > 2) begin
        k = int'($urandom % thr);
        set_head(s, t, 1);
        issue(s, t, 'h500 + i);
        repeat (k) tick();
        complete(s, t);
        watch(thr + 8, seen);
        check_eq("R4 random early", seen, 0);
        set_head(s, t, 0);
      end else begin
        probe(s, t, 'h600 + i, thr, "R2 random thr");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule